// File: doc/BRIEF.md
# Lockable Watchdog with Upper-Byte Reload

This block guards a chip against stalled software. A 16-bit up-counter starts counting on its own as soon as reset is released. It advances once every 2 or once every 128 system clocks, depending on a prescaler choice. Each service strobe restarts the count: the upper byte comes from a software-written reload byte and the lower byte is forced to zero. If the counter wraps past its all-ones value, the block raises an internal reset request. At the same time it pulls an active-low reset pin for external devices for a fixed 1024 clocks, then resumes counting with its reset defaults.

Software may switch the watchdog off only during start-up. Once the end-of-initialisation strobe has been seen, disable strobes are ignored until the next reset, either from the reset input or from the block's own overflow. The reload byte and prescaler choice are written together into a staging register. They only govern the count from the next service onwards, so a write never shortens or stretches the interval already in progress.

Top module: `wdog_guard`

## Requirements
- R1: While reset is applied, and immediately after it is released, `wd_rst_n_o` is high and `wd_rst_req_o` is low.
- R2: Without any service, the first overflow occurs 2 + 131072 clocks after the clock edge on which the reset input is sampled high (a two-stage reset synchroniser, then 65536 counts at divide-by-2).
- R3: A service taken on edge S loads the counter with the reload byte in bits 15:8 and zero in bits 7:0. Overflow then falls on edge S + (65536 − 256·R)·D. With R = 0xFF and D = 2, that is S + 512.
- R4: `cfg_slow_i` = 1 selects D = 128 and `cfg_slow_i` = 0 selects D = 2. With R = 0xFF and D = 128, overflow is at S + 32768.
- R5: A configuration write changes nothing for the interval already running. It is used only from the next service.
- R6: A disable strobe before end-of-initialisation stops counting, and no overflow occurs while disabled.
- R7: After an end-of-initialisation strobe, disable strobes have no effect and the watchdog keeps counting.
- R8: Repeated services spaced closer than the interval keep both reset outputs inactive.
- R9: On overflow, `wd_rst_n_o` goes low and `wd_rst_req_o` goes high together, for exactly 1024 clocks. No counting takes place meanwhile.
- R10: When the overflow pulse ends, the counter restarts from zero with the lock cleared. A disable strobe issued afterwards is accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| svc_i | input | 1 | Service strobe, one clock wide |
| dis_i | input | 1 | Disable strobe, honoured only before the lock is set |
| einit_i | input | 1 | End-of-initialisation strobe, sets the lock |
| cfg_we_i | input | 1 | Write strobe for the staging configuration |
| cfg_rld_i | input | 8 | Reload byte for counter bits 15:8 |
| cfg_slow_i | input | 1 | Prescaler choice: 0 = divide by 2, 1 = divide by 128 |
| wd_rst_req_o | output | 1 | Internal reset request, high during the overflow pulse |
| wd_rst_n_o | output | 1 | Active-low reset pin for external devices |

## Verification
A counter that holds a wrong value, or a prescaler phase that is off by one, shows up as a reset pulse on the wrong clock edge. The bench pins every expected pulse to an exact cycle, so a single-count error appears as a shifted falling edge within one interval. A stuck lock or enable shows at the ports as a pulse where none should occur, or a missing one, within one short 512-clock interval. A miscounted pulse length shows at the rising edge of the reset pin.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    WD_RUN  = 2'd0,
    WD_OFF  = 2'd1,
    WD_HOLD = 2'd2
  } wd_state_e;

  function automatic int unsigned width_of(int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n_o
);

  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= 1'b0;
        else         q <= 1'b1;
      end
      assign srst_n_o = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= '0;
        else         q <= {q[STAGES-2:0], 1'b1};
      end
      assign srst_n_o = q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/wdog_presc.sv
module wdog_presc #(
  parameter int DIV_FAST = 2,
  parameter int DIV_SLOW = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clr_i,
  input  logic slow_i,
  output logic tick_o
);

  localparam int PRE_W = wdog_pkg::width_of(DIV_SLOW);
  localparam logic [PRE_W-1:0] LIM_FAST = PRE_W'(DIV_FAST - 1);
  localparam logic [PRE_W-1:0] LIM_SLOW = PRE_W'(DIV_SLOW - 1);

  logic [PRE_W-1:0] pre_q, pre_d, lim;

  assign lim    = slow_i ? LIM_SLOW : LIM_FAST;
  assign tick_o = run_i && (pre_q >= lim);

  always_comb begin
    pre_d = pre_q;
    if (clr_i)      pre_d = '0;
    else if (run_i) pre_d = tick_o ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int CNT_W = 16,
  parameter int RLD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             load_i,
  input  logic [RLD_W-1:0] load_val_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);

  localparam int LOW_W = CNT_W - RLD_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign ovf_o = inc_i && (&cnt_q) && !load_i && !restart_i;
  assign cnt_o = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i)   cnt_d = '0;
    else if (load_i) cnt_d = {load_val_i, {LOW_W{1'b0}}};
    else if (inc_i)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl #(
  parameter int HOLD_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dis_i,
  input  logic einit_i,
  input  logic ovf_i,
  output logic run_o,
  output logic hold_o,
  output logic restart_o,
  output logic lock_o
);

  import wdog_pkg::*;

  localparam int HOLD_W = width_of(HOLD_CYC);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYC - 1);

  wd_state_e         st_q, st_d;
  logic [HOLD_W-1:0] hcnt_q, hcnt_d;
  logic              lock_q, lock_d;

  assign restart_o = (st_q == WD_HOLD) && (hcnt_q == HOLD_LAST);
  assign run_o     = (st_q == WD_RUN);
  assign hold_o    = (st_q == WD_HOLD);
  assign lock_o    = lock_q;

  always_comb begin
    st_d   = st_q;
    hcnt_d = hcnt_q;
    unique case (st_q)
      WD_RUN: begin
        if (ovf_i) begin
          st_d   = WD_HOLD;
          hcnt_d = '0;
        end else if (dis_i && !lock_q) begin
          st_d = WD_OFF;
        end
      end
      WD_OFF: st_d = WD_OFF;
      WD_HOLD: begin
        if (restart_o) begin
          st_d   = WD_RUN;
          hcnt_d = '0;
        end else begin
          hcnt_d = hcnt_q + 1'b1;
        end
      end
      default: st_d = WD_RUN;
    endcase
  end

  always_comb begin
    lock_d = lock_q;
    if (restart_o)                        lock_d = 1'b0;
    else if (einit_i && st_q != WD_HOLD)  lock_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WD_RUN;
      hcnt_q <= '0;
      lock_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      hcnt_q <= hcnt_d;
      lock_q <= lock_d;
    end
  end

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard #(
  parameter int CNT_W       = 16,
  parameter int RLD_W       = 8,
  parameter int DIV_FAST    = 2,
  parameter int DIV_SLOW    = 128,
  parameter int HOLD_CYC    = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc_i,
  input  logic             dis_i,
  input  logic             einit_i,
  input  logic             cfg_we_i,
  input  logic [RLD_W-1:0] cfg_rld_i,
  input  logic             cfg_slow_i,
  output logic             wd_rst_req_o,
  output logic             wd_rst_n_o
);

  logic             irst_n;
  logic             run, hold, restart, lock;
  logic             tick, ovf, svc_ok;
  logic [CNT_W-1:0] cnt_q;
  logic [RLD_W-1:0] sh_rld_q, sh_rld_d;
  logic             sh_slow_q, sh_slow_d;
  logic             act_slow_q, act_slow_d;

  wdog_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .arst_n   (rst_n),
    .srst_n_o (irst_n)
  );

  assign svc_ok = svc_i && !hold;

  // staging and active configuration: next state
  always_comb begin
    sh_rld_d   = sh_rld_q;
    sh_slow_d  = sh_slow_q;
    act_slow_d = act_slow_q;
    if (restart) begin
      sh_rld_d   = '0;
      sh_slow_d  = 1'b0;
      act_slow_d = 1'b0;
    end else begin
      if (cfg_we_i && !hold) begin
        sh_rld_d  = cfg_rld_i;
        sh_slow_d = cfg_slow_i;
      end
      if (svc_ok) act_slow_d = sh_slow_q;
    end
  end

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) begin
      sh_rld_q   <= '0;
      sh_slow_q  <= 1'b0;
      act_slow_q <= 1'b0;
    end else begin
      sh_rld_q   <= sh_rld_d;
      sh_slow_q  <= sh_slow_d;
      act_slow_q <= act_slow_d;
    end
  end

  wdog_presc #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_presc (
    .clk    (clk),
    .rst_n  (irst_n),
    .run_i  (run),
    .clr_i  (svc_ok || restart),
    .slow_i (act_slow_q),
    .tick_o (tick)
  );

  wdog_count #(.CNT_W(CNT_W), .RLD_W(RLD_W)) u_count (
    .clk        (clk),
    .rst_n      (irst_n),
    .restart_i  (restart),
    .load_i     (svc_ok),
    .load_val_i (sh_rld_q),
    .inc_i      (tick),
    .cnt_o      (cnt_q),
    .ovf_o      (ovf)
  );

  wdog_ctrl #(.HOLD_CYC(HOLD_CYC)) u_ctrl (
    .clk       (clk),
    .rst_n     (irst_n),
    .dis_i     (dis_i),
    .einit_i   (einit_i),
    .ovf_i     (ovf),
    .run_o     (run),
    .hold_o    (hold),
    .restart_o (restart),
    .lock_o    (lock)
  );

  assign wd_rst_req_o = hold;
  assign wd_rst_n_o   = !hold;

endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk #(
  parameter int CNT_W    = 16,
  parameter int RLD_W    = 8,
  parameter int HOLD_CYC = 1024
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irst_n,
  input logic             svc_ok,
  input logic             dis_i,
  input logic             tick,
  input logic             ovf,
  input logic             run,
  input logic             hold,
  input logic             lock,
  input logic [CNT_W-1:0] cnt_q,
  input logic [RLD_W-1:0] sh_rld_q,
  input logic             wd_rst_req_o,
  input logic             wd_rst_n_o
);

  localparam int LOW_W = CNT_W - RLD_W;
  localparam int LO_W  = $clog2(HOLD_CYC + 2);

  logic [LO_W-1:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           lo_cnt <= '0;
    else if (!wd_rst_n_o) lo_cnt <= lo_cnt + 1'b1;
    else                  lo_cnt <= '0;
  end

  p_fall_on_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n || !irst_n)
    $fell(wd_rst_n_o) |-> $past(ovf));

  p_svc_load_r3: assert property (@(posedge clk) disable iff (!rst_n || !irst_n)
    svc_ok |=> cnt_q == {$past(sh_rld_q), {LOW_W{1'b0}}});

  p_off_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n || !irst_n)
    (!run && !hold && !svc_ok) |=> $stable(cnt_q));

  p_dis_locked_r7: assert property (@(posedge clk) disable iff (!rst_n || !irst_n)
    (lock && dis_i && run) |=> (run || hold));

  p_lock_kept_r7: assert property (@(posedge clk) disable iff (!rst_n || !irst_n)
    (lock && !hold) |=> lock);

  p_pin_pair_r9: assert property (@(posedge clk) disable iff (!rst_n || !irst_n)
    wd_rst_req_o != wd_rst_n_o);

  p_hold_len_r9: assert property (@(posedge clk) disable iff (!rst_n || !irst_n)
    $rose(wd_rst_n_o) |-> lo_cnt == LO_W'(HOLD_CYC));

  p_no_tick_hold_r9: assert property (@(posedge clk) disable iff (!rst_n || !irst_n)
    hold |-> !tick);

  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n || !irst_n)
    $rose(wd_rst_n_o) |-> (cnt_q == '0 && !lock));

endmodule

bind wdog_guard wdog_guard_chk #(
  .CNT_W(CNT_W), .RLD_W(RLD_W), .HOLD_CYC(HOLD_CYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irst_n       (irst_n),
  .svc_ok       (svc_ok),
  .dis_i        (dis_i),
  .tick         (tick),
  .ovf          (ovf),
  .run          (run),
  .hold         (hold),
  .lock         (lock),
  .cnt_q        (cnt_q),
  .sh_rld_q     (sh_rld_q),
  .wd_rst_req_o (wd_rst_req_o),
  .wd_rst_n_o   (wd_rst_n_o)
);

// File: tb/sim_wdog_guard.sv
module sim_wdog_guard;

  localparam int CLK_PERIOD = 10;
  localparam int N_DEF      = 65536 * 2;
  localparam int N_FF_FAST  = 256 * 2;
  localparam int N_FF_SLOW  = 256 * 128;
  localparam int HOLD       = 1024;
  localparam int SYNC_LAT   = 2;
  localparam int WDOG_LIMIT = 195000;

  logic       clk = 1'b0;
  logic       rst_n, svc, dis, einit, we, slow;
  logic [7:0] rld;
  logic       wd_req, wd_rst_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_guard u0 (
    .clk(clk), .rst_n(rst_n), .svc_i(svc), .dis_i(dis), .einit_i(einit),
    .cfg_we_i(we), .cfg_rld_i(rld), .cfg_slow_i(slow),
    .wd_rst_req_o(wd_req), .wd_rst_n_o(wd_rst_n)
  );

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int unsigned at; string tag; } exp_t;
  exp_t        exp_q[$];
  exp_t        e_cur;
  int          n_chk = 0, n_fail = 0, n_rel = 0;
  int unsigned fall_at = 0;
  logic        prev_n = 1'b1;
  bit          ended = 0;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: compares reset pulses against the scoreboard queue
  always @(negedge clk) begin
    if (prev_n && !wd_rst_n) begin
      fall_at = cyc;
      if (exp_q.size() == 0) begin
        chk(0, "R6/R7/R8", "unexpected overflow at cycle", cyc, 0);
      end else begin
        e_cur = exp_q.pop_front();
        chk(cyc == e_cur.at, e_cur.tag, "overflow cycle", cyc, e_cur.at);
      end
      chk(wd_req == 1'b1, "R9", "request while pin low", wd_req, 1);
    end
    if (!prev_n && wd_rst_n) begin
      chk((cyc - fall_at) == HOLD, "R9", "pulse length", cyc - fall_at, HOLD);
      chk(wd_req == 1'b0, "R9", "request after pulse", wd_req, 0);
      n_rel++;
    end
    prev_n = wd_rst_n;
  end

  task automatic do_reset(output int unsigned k);
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(wd_rst_n == 1'b1 && wd_req == 1'b0, "R1", "outputs in reset", {wd_rst_n, wd_req}, 2);
    exp_q.delete();
    k = cyc;
    rst_n = 1'b1;
  endtask

  task automatic write_cfg(logic [7:0] r, logic s);
    @(negedge clk) begin we = 1'b1; rld = r; slow = s; end
    @(negedge clk) we = 1'b0;
  endtask

  task automatic service(output int unsigned s);
    @(negedge clk) svc = 1'b1;
    s = cyc + 1;
    @(negedge clk) svc = 1'b0;
  endtask

  task automatic strobe_dis();
    @(negedge clk) dis = 1'b1;
    @(negedge clk) dis = 1'b0;
  endtask

  task automatic strobe_einit();
    @(negedge clk) einit = 1'b1;
    @(negedge clk) einit = 1'b0;
  endtask

  task automatic wait_rel(int target);
    while (n_rel < target) @(negedge clk);
  endtask

  initial begin
    repeat (WDOG_LIMIT) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    finish_run();
  end

  initial begin
    int unsigned k, s;
    rst_n = 1'b0; svc = 0; dis = 0; einit = 0; we = 0; slow = 0; rld = '0;

    // R1, R2: default interval out of reset
    do_reset(k);
    @(negedge clk);
    chk(wd_rst_n == 1'b1 && wd_req == 1'b0, "R1", "outputs after release", {wd_rst_n, wd_req}, 2);
    exp_q.push_back('{at: k + SYNC_LAT + N_DEF, tag: "R2"});
    wait_rel(1);

    // R10: lock cleared after pulse, disable accepted
    strobe_dis();
    write_cfg(8'hFF, 1'b0);
    service(s);
    repeat (1500) @(negedge clk);
    chk(wd_rst_n == 1'b1 && n_rel == 1, "R10", "disable after restart", n_rel, 1);

    // R3, R5: short interval, staging write does not disturb it
    do_reset(k);
    repeat (5) @(negedge clk);
    write_cfg(8'hFF, 1'b0);
    service(s);
    exp_q.push_back('{at: s + N_FF_FAST, tag: "R3,R5"});
    write_cfg(8'h80, 1'b1);
    wait_rel(2);

    // R7, R8: lock set, disable ignored, services postpone overflow
    write_cfg(8'hFF, 1'b0);
    service(s);
    strobe_einit();
    strobe_dis();
    repeat (400) @(negedge clk);
    chk(wd_rst_n == 1'b1, "R7", "pin high before interval", wd_rst_n, 1);
    service(s);
    repeat (400) @(negedge clk);
    chk(wd_rst_n == 1'b1 && n_rel == 2, "R8", "no pulse while serviced", n_rel, 2);
    service(s);
    exp_q.push_back('{at: s + N_FF_FAST, tag: "R7"});
    wait_rel(3);

    // R4: slow prescaler
    write_cfg(8'hFF, 1'b1);
    service(s);
    exp_q.push_back('{at: s + N_FF_SLOW, tag: "R4"});
    wait_rel(4);

    // R6: disable before end of initialisation
    do_reset(k);
    repeat (3) @(negedge clk);
    strobe_dis();
    repeat (2000) @(negedge clk);
    chk(wd_rst_n == 1'b1 && n_rel == 4, "R6", "no pulse while disabled", n_rel, 4);
    chk(exp_q.size() == 0, "R2", "pending expectations", exp_q.size(), 0);

    finish_run();
  end

endmodule